// File: doc/BRIEF.md
# Banked Register Window Decoder

This block sits between a host bus and a peripheral's register file. The peripheral exposes more registers than fit in its 16-byte I/O window, so the registers are split into banks. The block matches each host access against a window base formed from a 3-bit base-select input and a configuration value held elsewhere. It then steers the access to one register set. The word at offset 0xE holds the bank number. That word is present in every bank and chooses which set answers at offsets 0x0 to 0xD.

Host accesses are doubleword-addressed with four byte-lane enables, so byte, word and doubleword transfers all use the same path. A register defined as two separate byte registers is written one lane at a time. Banks 0 to 3 hold internal 16-bit registers. One bank is passed through to an external register port. The remaining bank numbers read as zero and drop writes. Read data is combinational in the access cycle, and a write takes effect at the clock edge that ends the access.

Top module: `bank_window_dec`

## Requirements
- R1: An access hits the window only when `host_addr[ADDR_W-1:4]` equals `{cfg_base, base_sel}`. An access that misses changes no register and no bank, raises no `ext_stb`, and returns zero read data.
- R2: The bank-select word answers in every bank at dword index 3 (`host_addr[3:2]`=3), lanes 2 and 3 (byte 0xE is lane 2, byte 0xF is lane 3). A write with lane 2 enabled loads the bank from `host_wdata[18:16]`, and lane 3 writes are ignored. It reads back as `{8'h33, 5'b0, bank}`.
- R3: After reset the bank is 0, and the register at word w (offset 2w, w = 0..6) of bank b reads `{4'hD, b[3:0], 4'h0, w[3:0]}`.
- R4: In banks 0 to 3, word w sits in dword w/2, in the low half (lanes 0,1) when w is even and in the high half (lanes 2,3) when w is odd. Its bits 7:0 are at the even byte and bits 15:8 at the odd byte. Each enabled lane writes only its own byte.
- R5: Offset 0xC of bank 0 is reserved: it reads zero and ignores writes.
- R6: Banks 4, 5 and 6 read zero at offsets 0x0 to 0xD and ignore writes there.
- R7: In bank 7 an access to offsets 0x0 to 0xD raises `ext_stb` with `ext_we` = `host_we`, `ext_dw` = dword index, and `ext_be` = the host lanes with lanes 2,3 cleared at dword 3. `ext_wdata` equals `host_wdata`, and reads return `ext_rdata` in those lanes. No strobe is raised when no such lane is enabled.
- R8: A doubleword write at dword 3 writes the 0xC word under the bank that was current before the access. The new bank applies from the next access.
- R9: `host_rdata` is zero except during an in-window read, and disabled lanes read zero.
- R10: Every register accepts byte, word and doubleword accesses with any lane combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| base_sel | input | 3 | Low bits of the window base |
| cfg_base | input | ADDR_W-7 | High bits of the window base from configuration storage |
| host_req | input | 1 | Access valid this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W-2 | Doubleword address |
| host_be | input | 4 | Byte-lane enables |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data |
| ext_stb | output | 1 | External register access strobe |
| ext_we | output | 1 | External write |
| ext_dw | output | 2 | Dword index within window |
| ext_be | output | 4 | External lane enables |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |

## Verification
The bench visits every bank number, every dword index and all fifteen non-empty lane masks. Each write is followed by a full read and by a read under the same mask, which separates lane isolation from bank steering. Accesses at all 63 wrong base values show whether the window compare looks at every base bit. A doubleword write at dword 3 that also changes the bank distinguishes old-bank from new-bank decoding of the 0xC word. Running the same sweeps in bank 7 checks the external strobe, its lane masking and its read return against the internal banks.

// File: rtl/bank_window_dec.sv
module bank_window_dec #(
  parameter int ADDR_W = 10,
  parameter int NUM_BANKS = 4,
  parameter int EXT_BANK = 7,
  parameter logic [7:0] BSEL_HI = 8'h33,
  parameter logic [3:0] DFLT_TAG = 4'hD,
  parameter logic [NUM_BANKS*7-1:0] RSV_MASK = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        base_sel,
  input  logic [ADDR_W-8:0] cfg_base,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:2] host_addr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              ext_stb,
  output logic              ext_we,
  output logic [1:0]        ext_dw,
  output logic [3:0]        ext_be,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata
);
  localparam int WPB  = 7;
  localparam int NREG = NUM_BANKS * WPB;

  logic [2:0]         bank_q;
  logic               hit, top_dw, in_ext, wr_hit;
  logic [1:0]         dw;
  logic [3:0]         lane_be;
  logic [NREG*16-1:0] regs_flat;
  logic [31:0]        rd_raw;

  assign hit     = host_req && (host_addr[ADDR_W-1:4] == {cfg_base, base_sel});
  assign dw      = host_addr[3:2];
  assign top_dw  = (dw == 2'd3);
  assign in_ext  = (bank_q == 3'(EXT_BANK));
  assign wr_hit  = hit && host_we;
  assign lane_be = host_be & {~top_dw, ~top_dw, 2'b11};

  assign ext_stb   = hit && in_ext && (lane_be != 4'b0);
  assign ext_we    = host_we;
  assign ext_dw    = dw;
  assign ext_be    = (hit && in_ext) ? lane_be : 4'b0;
  assign ext_wdata = host_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bank_q <= 3'd0;
    else if (wr_hit && top_dw && host_be[2]) bank_q <= host_wdata[18:16];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam int B = g / WPB;
      localparam int W = g % WPB;
      localparam int H = W % 2;
      localparam int D = W / 2;
      if (RSV_MASK[g]) begin : g_rsv
        assign regs_flat[g*16 +: 16] = 16'h0;
      end else begin : g_impl
        logic [15:0] q;
        logic        sel;
        assign sel = wr_hit && (bank_q == 3'(B)) && (dw == 2'(D));
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q <= {DFLT_TAG, 4'(B), 4'h0, 4'(W)};
          else if (sel) begin
            if (host_be[2*H])   q[7:0]  <= host_wdata[16*H +: 8];
            if (host_be[2*H+1]) q[15:8] <= host_wdata[16*H+8 +: 8];
          end
        assign regs_flat[g*16 +: 16] = q;
      end
    end
  endgenerate

  always_comb begin
    rd_raw = 32'h0;
    for (int h = 0; h < 2; h++) begin
      if (top_dw && h == 1)
        rd_raw[16*h +: 16] = {BSEL_HI, 5'b0, bank_q};
      else if (in_ext)
        rd_raw[16*h +: 16] = ext_rdata[16*h +: 16];
      else if (int'(bank_q) < NUM_BANKS)
        rd_raw[16*h +: 16] = regs_flat[(int'(bank_q)*WPB + int'(dw)*2 + h)*16 +: 16];
    end
  end

  assign host_rdata = (hit && !host_we) ?
    (rd_raw & {{8{host_be[3]}}, {8{host_be[2]}}, {8{host_be[1]}}, {8{host_be[0]}}}) : 32'h0;
endmodule

module bank_window_dec_chk #(
  parameter int ADDR_W = 10,
  parameter int EXT_BANK = 7,
  parameter logic [7:0] BSEL_HI = 8'h33
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        base_sel,
  input logic [ADDR_W-8:0] cfg_base,
  input logic              host_req,
  input logic              host_we,
  input logic [ADDR_W-1:2] host_addr,
  input logic [3:0]        host_be,
  input logic [31:0]       host_wdata,
  input logic [31:0]       host_rdata,
  input logic              ext_stb,
  input logic [1:0]        ext_dw,
  input logic [3:0]        ext_be,
  input logic [2:0]        bank_q
);
  logic inwin;
  assign inwin = host_req && (host_addr[ADDR_W-1:4] == {cfg_base, base_sel});

  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inwin |-> (!ext_stb && host_rdata == 32'h0));

  a_r1_miss_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !inwin |=> $stable(bank_q));

  a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (inwin && host_we && host_addr[3:2] == 2'd3 && host_be[2]) |=> bank_q == $past(host_wdata[18:16]));

  a_r2_bsel_read: assert property (@(posedge clk) disable iff (!rst_n)
    (inwin && !host_we && host_addr[3:2] == 2'd3 && host_be[3:2] == 2'b11)
      |-> host_rdata[31:16] == {BSEL_HI, 5'b0, bank_q});

  a_r7_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ext_stb |-> (inwin && bank_q == 3'(EXT_BANK)));

  a_r7_ext_top_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_stb && ext_dw == 2'd3) |-> ext_be[3:2] == 2'b00);

  a_r9_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !host_be[0] |-> host_rdata[7:0] == 8'h0);
endmodule

bind bank_window_dec bank_window_dec_chk #(
  .ADDR_W(ADDR_W), .EXT_BANK(EXT_BANK), .BSEL_HI(BSEL_HI)
) chk_i (
  .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .cfg_base(cfg_base),
  .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
  .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .ext_stb(ext_stb), .ext_dw(ext_dw), .ext_be(ext_be), .bank_q(bank_q)
);

// File: tb/bank_window_dec_tb_top.sv
module bank_window_dec_tb_top;
  localparam logic [5:0]  WIN     = 6'b010_101;
  localparam logic [31:0] EXT_PAT = 32'h6B2C_91E4;

  logic        clk = 0, rst_n = 0;
  logic        host_req = 0, host_we = 0;
  logic [9:2]  host_addr = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        ext_stb, ext_we;
  logic [1:0]  ext_dw;
  logic [3:0]  ext_be;
  logic [31:0] ext_wdata;
  logic [31:0] ext_rdata = EXT_PAT;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [15:0] mreg [4][7];
  logic [2:0]  mbank;

  bank_window_dec dut_i (
    .clk(clk), .rst_n(rst_n), .base_sel(WIN[2:0]), .cfg_base(WIN[5:3]),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ext_stb(ext_stb), .ext_we(ext_we), .ext_dw(ext_dw), .ext_be(ext_be),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_half(int w);
    if (w == 7) return {8'h33, 5'b0, mbank};
    if (mbank == 3'd7) return EXT_PAT[16*(w%2) +: 16];
    if (mbank < 3'd4) return (mbank == 3'd0 && w == 6) ? 16'h0 : mreg[mbank][w];
    return 16'h0;
  endfunction

  function automatic logic [31:0] exp_rd(int idx, logic [3:0] be);
    logic [31:0] v;
    v = {exp_half(idx*2+1), exp_half(idx*2)};
    for (int k = 0; k < 4; k++) if (!be[k]) v[8*k +: 8] = 8'h0;
    return v;
  endfunction

  task automatic acc(logic [5:0] win, logic we, int idx, logic [3:0] be,
                     logic [31:0] wd, string tag);
    logic inwin, estb;
    logic [3:0] mbe;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = {win, 2'(idx)};
    host_be = be; host_wdata = wd;
    #1;
    inwin = (win == WIN);
    check({tag, " rdata"}, host_rdata, (inwin && !we) ? exp_rd(idx, be) : 32'h0);
    mbe  = (idx == 3) ? (be & 4'b0011) : be;
    estb = inwin && mbank == 3'd7 && mbe != 4'b0;
    check({tag, " ext_stb"}, {31'b0, ext_stb}, {31'b0, estb});
    if (estb) begin
      check({tag, " ext ctl"}, {25'b0, ext_we, ext_dw, ext_be}, {25'b0, we, 2'(idx), mbe});
      check({tag, " ext_wdata"}, ext_wdata, wd);
    end
    @(posedge clk);
    if (inwin && we)
      for (int h = 0; h < 2; h++) begin
        int w;
        w = idx*2 + h;
        if (w == 7) begin
          if (be[2]) mbank = wd[18:16];
        end else if (mbank < 3'd4 && !(mbank == 3'd0 && w == 6)) begin
          if (be[2*h])   mreg[mbank][w][7:0]  = wd[16*h +: 8];
          if (be[2*h+1]) mreg[mbank][w][15:8] = wd[16*h+8 +: 8];
        end
      end
    #1 host_req = 0;
  endtask

  task automatic set_bank(int b);
    acc(WIN, 1, 3, 4'b0100, {13'h0, 3'(b), 16'h0}, "R2 bank write");
  endtask

  function automatic string btag(int b);
    if (b == 7) return "R7";
    if (b >= 4) return "R6";
    return "R4";
  endfunction

  initial begin
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 7; w++)
        mreg[b][w] = {4'hD, 4'(b), 4'h0, 4'(w)};
    mbank = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R3: reset values in every bank, bank select at 0
    acc(WIN, 0, 3, 4'b1111, 32'h0, "R3 reset bank");
    for (int b = 0; b < 8; b++) begin
      set_bank(b);
      for (int i = 0; i < 4; i++) acc(WIN, 0, i, 4'b1111, 32'h0, "R3 reset read");
    end

    // R4 R6 R7 R9 R10: every bank, dword and lane mask
    for (int b = 0; b < 8; b++) begin
      set_bank(b);
      for (int i = 0; i < 4; i++)
        for (int be = 1; be < 16; be++) begin
          logic [31:0] wd;
          wd = 32'h9E37_79B9 * 32'(b*64 + i*16 + be + 1);
          if (i == 3) wd[18:16] = 3'(b);
          acc(WIN, 1, i, 4'(be), wd, {btag(b), " R10 write"});
          acc(WIN, 0, i, 4'b1111, 32'h0, {btag(b), " readback"});
          acc(WIN, 0, i, 4'(be), 32'h0, "R9 lane read");
        end
    end

    // R5: reserved word of bank 0
    set_bank(0);
    acc(WIN, 1, 3, 4'b0011, 32'h0000_FFFF, "R5 reserved write");
    acc(WIN, 0, 3, 4'b1111, 32'h0, "R5 reserved read");
    check("R5 reserved zero", {16'h0, exp_half(6)}, 32'h0);

    // R8: dword write at 0xC changes bank; low word uses old bank
    set_bank(1);
    acc(WIN, 1, 3, 4'b1111, {16'h0002, 16'hBEEF}, "R8 combined write");
    check("R8 bank after", {29'b0, mbank}, 32'd2);
    acc(WIN, 0, 3, 4'b1111, 32'h0, "R8 new bank word");
    set_bank(1);
    acc(WIN, 0, 3, 4'b0011, 32'h0, "R8 old bank word");
    check("R8 model old bank", {16'h0, mreg[1][6]}, 32'h0000_BEEF);

    // R1: every wrong base value, from bank 7 and from bank 2
    for (int pass = 0; pass < 2; pass++) begin
      set_bank(pass == 0 ? 7 : 2);
      for (int t = 0; t < 64; t++)
        if (6'(t) != WIN) begin
          acc(6'(t), 1, t % 4, 4'b1111, {13'h0, 3'd5, 16'hA5A5}, "R1 miss write");
          acc(6'(t), 0, t % 4, 4'b1111, 32'h0, "R1 miss read");
        end
      for (int i = 0; i < 4; i++) acc(WIN, 0, i, 4'b1111, 32'h0, "R1 state kept");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule